// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned `WIDTH`-bit operands over several clock cycles and returns a product twice as wide. It uses one adder for the whole operation. When a start request is accepted, the block captures both operands. After that, it runs one step for each bit of the second operand.

On each step the block looks at only the lowest bit of a right-shifting copy of the second operand. If that bit is set, it adds a left-shifting copy of the first operand into an accumulator. The accumulator therefore holds a running sum of the partial products, rather than storing each one to add at the end.

The caller pulses `start` while `busy` is low, then waits for `done`. The accumulator drives the product outputs directly, split into an upper half and a lower half.

Top module: `shiftmul_top`

## Requirements
- R1: In the cycle `done` is high, `{prod_hi, prod_lo}` equals `op_a * op_b` as captured at acceptance, as a full 2*WIDTH-bit unsigned product, with `prod_hi` holding the upper WIDTH bits.
- R2: A cycle with `start` high and `busy` low accepts a request. In the next cycle `busy` is 1 and both product halves are 0.
- R3: After acceptance, `busy` stays high for exactly WIDTH cycles. `busy` falls in the same cycle that `done` rises.
- R4: `done` is high for exactly one cycle per accepted request and is otherwise low.
- R5: While `busy` is high, the block ignores `start` and any change on `op_a` or `op_b`. The step sequence and the final product are unchanged.
- R6: After step i (1..WIDTH) of a request, the product equals `op_a * (op_b mod 2^i)`. A step with a clear multiplier bit leaves the product unchanged, and no step decreases it.
- R7: While the block is idle and no request is accepted, the product outputs hold their last value.
- R8: After reset, `busy` and `done` are 0 and both product halves are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; acted on only while idle |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse marking a finished product |
| prod_hi | output | WIDTH | Upper half of the product |
| prod_lo | output | WIDTH | Lower half of the product |

## Verification
The assertions assume that `start` is only taken as a request while `busy` is low. They also assume the operands are sampled only at acceptance, so stray activity on the inputs while busy must not disturb the step count or the accumulator.

The stimulus drives `start` high together with different operand values in the middle of runs, to exercise those assumptions. It also issues a new request in the same cycle that `done` is high, and leaves idle gaps between requests. The operands include the extremes (zero, one, all ones and alternating bit patterns) as well as pseudo-random values, all within the WIDTH-bit unsigned range.

// File: rtl/shiftmul_pkg.sv
package shiftmul_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;
endpackage

// File: rtl/shiftmul_ctrl.sv
module shiftmul_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   import shiftmul_pkg::*;

   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   run_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign busy = (state_q == ST_RUN);
   assign step = busy;
   assign load = start && !busy;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               if (cnt_q == LAST) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R5: requests during a run do not restart the step counter
   a_r5_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + CW'(1)));

   // R4: done never lasts two cycles
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: the final step ends the run and raises done
   a_r3_last_step_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q == LAST) |=> (done && !busy));
endmodule

// File: rtl/shiftmul_dpath.sv
module shiftmul_dpath #(
   parameter int WIDTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   output logic [2*WIDTH-1:0] acc
);
   localparam int PW = 2 * WIDTH;

   logic [PW-1:0]    mcand_q;
   logic [WIDTH-1:0] mplier_q;
   logic [PW-1:0]    acc_q;

   assign acc = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
      end else if (load) begin
         mcand_q  <= {{WIDTH{1'b0}}, op_a};
         mplier_q <= op_b;
         acc_q    <= '0;
      end else if (step) begin
         if (mplier_q[0]) begin
            acc_q <= acc_q + mcand_q;
         end
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_q >> 1;
      end
   end

   // R6: the running sum never decreases during a run
   a_r6_sum_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (acc_q >= $past(acc_q)));

   // R6: a clear multiplier bit adds nothing
   a_r6_zero_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !mplier_q[0]) |=> $stable(acc_q));
endmodule

// File: rtl/shiftmul_top.sv
module shiftmul_top #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] prod_hi,
   output logic [WIDTH-1:0] prod_lo
);
   localparam int PW = 2 * WIDTH;

   if (WIDTH < 2) begin : g_width_check
      $error("shiftmul_top: WIDTH must be at least 2");
   end

   logic          load;
   logic          step;
   logic [PW-1:0] acc;

   shiftmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   shiftmul_dpath #(.WIDTH(WIDTH)) u_dpath (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .op_a  (op_a),
      .op_b  (op_b),
      .acc   (acc)
   );

   assign prod_hi = acc[PW-1:WIDTH];
   assign prod_lo = acc[WIDTH-1:0];

   // R2: an accepted request clears the product and starts the run
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && prod_hi == '0 && prod_lo == '0));

   // R3: busy falls only together with done
   a_r3_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R7: idle without a request keeps the product
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

// File: tb/shiftmul_top_tb.sv
module shiftmul_top_tb;
   localparam int W = 8;
   localparam int PW = 2 * W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         busy;
   logic         done;
   logic [W-1:0] prod_hi;
   logic [W-1:0] prod_lo;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // behavioural reference state
   bit            m_busy = 0;
   bit            m_done = 0;
   int            m_step = 0;
   longint        m_prod = 0;
   longint        m_a = 0;
   longint        m_b = 0;

   always #4 clk = ~clk;

   shiftmul_top #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
   );

   task automatic check(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // reference model advances on every rising edge
   always @(posedge clk) begin
      if (rst_n) begin
         if (!m_busy && start) begin
            m_a = longint'(op_a);
            m_b = longint'(op_b);
            m_prod = 0;
            m_step = 0;
            m_busy = 1;
            m_done = 0;
         end else if (m_busy) begin
            if (((m_b >> m_step) & 1) == 1) m_prod = m_prod + (m_a << m_step);
            m_step++;
            if (m_step == W) begin
               m_busy = 0;
               m_done = 1;
            end
         end else begin
            m_done = 0;
         end
      end
   end

   // compare away from the active edge, every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         check("R3", "busy", longint'(busy), longint'(m_busy));
         check("R4", "done", longint'(done), longint'(m_done));
         if (m_busy)
            check("R6", "partial product", longint'({prod_hi, prod_lo}), m_prod);
         else if (m_done)
            check("R1", "final product", longint'({prod_hi, prod_lo}), m_a * m_b);
         else
            check("R7", "held product", longint'({prod_hi, prod_lo}), m_prod);
      end
   end

   task automatic run_mul(logic [W-1:0] a, logic [W-1:0] b, bit disturb);
      @(negedge clk);
      start = 1'b1; op_a = a; op_b = b;
      @(negedge clk);
      check("R2", "product cleared", longint'({prod_hi, prod_lo}), 0);
      check("R2", "busy after start", longint'(busy), 1);
      start = disturb; op_a = ~a; op_b = ~b;
      while (!done) begin
         @(negedge clk);
         if (disturb) begin
            start = ~start; op_a = op_a + 8'd37; op_b = op_b ^ 8'h5A;
         end
      end
      start = 1'b0;
      check(disturb ? "R5" : "R1", "product", longint'({prod_hi, prod_lo}),
            longint'(a) * longint'(b));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8", "busy at reset", longint'(busy), 0);
      check("R8", "done at reset", longint'(done), 0);
      check("R8", "product at reset", longint'({prod_hi, prod_lo}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_mul(8'd0, 8'd173, 0);
      run_mul(8'd173, 8'd0, 0);
      run_mul(8'd1, 8'd1, 0);
      run_mul(8'hFF, 8'hFF, 0);
      run_mul(8'hAA, 8'h55, 0);
      run_mul(8'h80, 8'h81, 1);
      run_mul(8'd13, 8'd200, 1);
      repeat (5) @(negedge clk);
      check("R7", "idle hold", longint'({prod_hi, prod_lo}), 13 * 200);
      // back-to-back: new request in the done cycle
      @(negedge clk);
      start = 1'b1; op_a = 8'd9; op_b = 8'd7;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      start = 1'b1; op_a = 8'd250; op_b = 8'd3;
      @(negedge clk);
      start = 1'b0;
      check("R2", "restart in done cycle", longint'(busy), 1);
      while (!done) @(negedge clk);
      check("R1", "back-to-back product", longint'({prod_hi, prod_lo}), 750);
      for (int i = 0; i < 30; i++) begin
         run_mul(W'($urandom % 256), W'($urandom % 256), (i % 3) == 0);
         repeat (i % 4) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule